// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a memory-mapped watchdog timer driven by a timebase counter that runs on every clock. The watchdog runs while it is enabled. Each time the low `IVL_LOG2` bits of the timebase wrap, the interval has expired. On the first unserviced expiry the block sets a pending flag and raises a one-cycle interrupt. If a second expiry arrives while that flag is still set, the block issues a reset request pulse that lasts a fixed number of cycles. The worst-case time from the last service to reset is therefore two intervals.

Software drives the block through a plain single-cycle register port. A write takes effect on the clock edge where the write strobe is high. Read data appears on the cycle after the read strobe. The port has no back-pressure and needs no handshake, because the register file accepts an access on every cycle. Software services the watchdog by writing a one to the pending flag. That write clears the flag and restarts the interval. Two enable bits, one in each control register, both have to be cleared before the timer stops, so one stray write cannot disable it. An optional lock mode keeps both enable bits set once the watchdog is running.

The reset-cause flag is set when the reset request fires. Only a power-on reset or a write of one clears it, so boot software can find out why the system restarted.

Top module: `twostage_wdt`

## Requirements
- R1: After `rst_n` is released, `wdt_irq` and `wdt_rst_req` are low and the two control registers read 0.
- R2: The register map uses byte offsets. Offset 0x0 is control A: bit 3 is the reset-cause flag, bit 2 is the pending flag, bit 1 is enable A, and bit 0 reads 0. Offset 0x4 is control B: bit 0 is enable B. Offset 0x8 is the timebase count. All other offsets read 0. Read data is valid on the cycle after `bus_rd`.
- R3: The timebase increments on every cycle, whether or not the watchdog is enabled. A write to control A with bit 2 set zeroes it. After such a write, back-to-back reads return 0 then 1, and a read issued k cycles after the write returns k-1.
- R4: While running, the first expiry comes 2^IVL_LOG2 cycles after the last service. It sets the pending flag and raises `wdt_irq` for exactly one cycle.
- R5: An expiry while the pending flag is set raises `wdt_rst_req` for exactly PULSE_CYCLES cycles. The same edge sets the reset-cause flag and clears both the pending flag and the timebase. No interrupt is raised for this expiry.
- R6: Writing 1 to control A bit 3 clears the reset-cause flag and does not restart the interval. Writing 0 to bits 3 and 2 leaves both flags unchanged.
- R7: The watchdog runs while enable A or enable B is set. With only one of them set it still expires. With both clear, no interrupt or reset request occurs.
- R8: With ENABLE_ONCE=1, once either enable bit is set, writes of 0 to the enable bits are ignored.
- R9: The reset-cause flag stays set after the reset request pulse ends, until software writes a 1 to it.
- R10: A service write on the same edge as an expiry wins: neither an interrupt nor a reset request results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd`, 0 otherwise |
| wdt_irq | output | 1 | One-cycle interrupt on the first expiry |
| wdt_rst_req | output | 1 | Reset request pulse on the second expiry |

## Verification
The assertions check the following on every cycle:
- the interrupt never lasts more than one cycle;
- the reset request pulse keeps its length and never restarts while it is active;
- a service write always zeroes the timebase;
- the reset-cause flag persists;
- the enable bits stay set in lock mode.

The bench's timed scenarios cover the rest:
- the exact expiry cycles;
- the two-interval path to reset;
- the clear-on-write semantics;
- running on a single enable bit;
- the quiet behaviour after a full stop;
- a service write that collides with an expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // register byte offsets
  localparam int OFF_CTRL_A = 'h0;
  localparam int OFF_CTRL_B = 'h4;
  localparam int OFF_TBASE  = 'h8;
  // control A bit positions
  localparam int BIT_CAUSE   = 3;
  localparam int BIT_PENDING = 2;
  localparam int BIT_EN_A    = 1;
  // control B bit positions
  localparam int BIT_EN_B    = 0;

  typedef enum logic [1:0] {
    SEL_CTRL_A = 2'd0,
    SEL_CTRL_B = 2'd1,
    SEL_TBASE  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int DATA_W   = 32,
  parameter int IVL_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  localparam logic [IVL_LOG2-1:0] WRAP_VAL = '1;

  logic [DATA_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign count  = cnt_q;
  assign expire = run && (cnt_q[IVL_LOG2-1:0] == WRAP_VAL);

  // R3: a service or reset issue always restarts the timebase at zero
  a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R3: otherwise the timebase advances by one per cycle
  a_r3_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_CYCLES);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= LOAD_VAL;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != '0);

  // R5: the pulse never ends early
  a_r5_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q > 1) |=> pulse);
  // R5: the pulse starts high the edge after start
  a_r5_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pulse);
  // R5: no retrigger while a pulse is running
  a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !pulse);
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] tbase,
  input  logic              expire,
  output logic              run,
  output logic              service,
  output logic              fire_rst,
  output logic              pending,
  output logic              irq
);
  reg_sel_e    sel;
  logic        wr_a, wr_b, cause_clr, expire_eff, lock;
  logic        en_a_q, en_b_q, pend_q, cause_q, irq_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic        unused_wdata;

  always_comb begin
    if      (addr == ADDR_W'(OFF_CTRL_A)) sel = SEL_CTRL_A;
    else if (addr == ADDR_W'(OFF_CTRL_B)) sel = SEL_CTRL_B;
    else if (addr == ADDR_W'(OFF_TBASE))  sel = SEL_TBASE;
    else                                  sel = SEL_NONE;
  end

  assign unused_wdata = ^wdata;
  assign wr_a       = wr && (sel == SEL_CTRL_A);
  assign wr_b       = wr && (sel == SEL_CTRL_B);
  assign service    = wr_a && wdata[BIT_PENDING];
  assign cause_clr  = wr_a && wdata[BIT_CAUSE];
  assign expire_eff = expire && !service;
  assign fire_rst   = expire_eff && pend_q;
  assign run        = en_a_q || en_b_q;
  assign lock       = ENABLE_ONCE && run;

  // pending flag and interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= expire_eff && !pend_q;
      if (service)         pend_q <= 1'b0;
      else if (expire_eff) pend_q <= !pend_q;
    end
  end

  // reset-cause flag: only power-on or write-one clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cause_q <= 1'b0;
    else if (fire_rst)  cause_q <= 1'b1;
    else if (cause_clr) cause_q <= 1'b0;
  end

  // split enable bits, optionally locked once running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a_q <= 1'b0;
      en_b_q <= 1'b0;
    end else begin
      if (wr_a) en_a_q <= lock ? (en_a_q | wdata[BIT_EN_A]) : wdata[BIT_EN_A];
      if (wr_b) en_b_q <= lock ? (en_b_q | wdata[BIT_EN_B]) : wdata[BIT_EN_B];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL_A: begin
        rd_mux[BIT_CAUSE]   = cause_q;
        rd_mux[BIT_PENDING] = pend_q;
        rd_mux[BIT_EN_A]    = en_a_q;
      end
      SEL_CTRL_B: rd_mux[BIT_EN_B] = en_b_q;
      SEL_TBASE:  rd_mux = tbase;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd ? rd_mux : '0;
  end

  assign rdata   = rdata_q;
  assign pending = pend_q;
  assign irq     = irq_q;

  // R4: the interrupt is a single-cycle pulse
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R4: an interrupt always comes with the pending flag set
  a_r4_irq_with_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> pend_q);
  // R9: the cause flag survives everything except a write of one
  a_r9_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q && !cause_clr) |=> cause_q);
  // R7: with both enables clear, nothing expires
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a_q && !en_b_q) |=> !irq_q);

  generate
    if (ENABLE_ONCE) begin : g_lock_chk
      // R8: enable bits cannot be cleared once the watchdog is running
      a_r8_en_a_locked: assert property (@(posedge clk) disable iff (!rst_n)
        en_a_q |=> en_a_q);
      a_r8_en_b_locked: assert property (@(posedge clk) disable iff (!rst_n)
        en_b_q |=> en_b_q);
    end
  endgenerate
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt #(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 4,
  parameter int IVL_LOG2     = 6,
  parameter int PULSE_CYCLES = 4,
  parameter bit ENABLE_ONCE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  logic [DATA_W-1:0] tb_count;
  logic tb_expire, run, service, fire_rst, pending, tb_clr;

  assign tb_clr = service || fire_rst;

  wdt_timebase #(.DATA_W(DATA_W), .IVL_LOG2(IVL_LOG2)) u_tbase (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(tb_clr),
    .count(tb_count), .expire(tb_expire));

  wdt_ctrl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ENABLE_ONCE(ENABLE_ONCE)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .rdata(bus_rdata), .tbase(tb_count), .expire(tb_expire),
    .run(run), .service(service), .fire_rst(fire_rst), .pending(pending),
    .irq(wdt_irq));

  wdt_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(fire_rst), .pulse(wdt_rst_req));

  // R5: the reset request rises with the pending flag just cleared
  a_r5_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |-> (!pending && !wdt_irq));
  // R5: a reset request is only ever preceded by a pending state
  a_r5_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |-> $past(pending));
endmodule

// File: tb/tb_twostage_wdt.sv
module tb_twostage_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_rd = 1'b0;
  logic [DW-1:0] rdata, rdata_once;
  logic irq, rst_req, irq_once, rst_req_once;

  int n_checks = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twostage_wdt dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata),
    .wdt_irq(irq), .wdt_rst_req(rst_req));

  twostage_wdt #(.ENABLE_ONCE(1'b1)) dut_once (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_once),
    .wdt_irq(irq_once), .wdt_rst_req(rst_req_once));

  task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read data is due on the negedge after the strobe edge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", rdata, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int quiet_err;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 0);
    check(rst_req == 1'b0, "R1 rst_req after reset", {31'b0, rst_req}, 0);
    rd(4'h0, 32'h0, "R1 ctrl A after reset");
    rd(4'h4, 32'h0, "R1 ctrl B after reset");
    rd(4'hC, 32'h0, "R2 unmapped offset reads 0");

    // R3 timebase restart and free running while disabled
    wr(4'h0, 32'h4);
    rd(4'h8, 32'd0, "R3 timebase first read after service");
    rd(4'h8, 32'd1, "R3 timebase consecutive read");
    wait_cyc(10);
    rd(4'h8, 32'd12, "R3 timebase read 13 cycles after service");

    // R7 quiet while disabled
    quiet_err = 0;
    for (int i = 0; i < 80; i++) begin
      if (irq || rst_req) quiet_err++;
      @(negedge clk);
    end
    check(quiet_err == 0, "R7 no event while disabled", quiet_err, 0);

    // start: service + clear + enable A, then enable B
    wr(4'h0, 32'hE);
    wr(4'h4, 32'h1);
    wait_cyc(62);
    check(irq == 1'b0, "R4 no irq before interval", {31'b0, irq}, 0);
    wait_cyc(1);
    check(irq == 1'b1, "R4 irq at first expiry", {31'b0, irq}, 1);
    rd(4'h0, 32'h6, "R4 pending flag set");
    check(irq == 1'b0, "R4 irq lasts one cycle", {31'b0, irq}, 0);
    wait_cyc(62);
    check(rst_req == 1'b0, "R5 no reset before second expiry", {31'b0, rst_req}, 0);
    wait_cyc(1);
    check(rst_req == 1'b1, "R5 reset at second expiry", {31'b0, rst_req}, 1);
    check(irq == 1'b0, "R5 no irq on second expiry", {31'b0, irq}, 0);
    wait_cyc(3);
    check(rst_req == 1'b1, "R5 reset pulse last cycle", {31'b0, rst_req}, 1);
    wait_cyc(1);
    check(rst_req == 1'b0, "R5 reset pulse ends", {31'b0, rst_req}, 0);
    rd(4'h0, 32'hA, "R9 cause flag kept after pulse, R5 pending cleared");

    // R6 write-one-to-clear
    wr(4'h0, 32'h2);
    rd(4'h0, 32'hA, "R6 writing zeros keeps flags");
    wr(4'h0, 32'hA);
    rd(4'h0, 32'h2, "R6 writing one clears cause flag");

    // R10 service on the expiry edge
    wait_cyc(54);
    wr(4'h0, 32'h6);
    check(irq == 1'b0, "R10 service wins over expiry", {31'b0, irq}, 0);
    rd(4'h0, 32'h2, "R10 no pending after collision");

    // R7 one enable bit keeps it running
    wr(4'h0, 32'h0);
    wait_cyc(62);
    check(irq == 1'b1, "R7 runs on enable B alone", {31'b0, irq}, 1);
    rd(4'h0, 32'h4, "R7 pending with enable A clear");
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h4);
    rd(4'h0, 32'h0, "R7 ctrl A after stop");
    check(rdata_once == 32'h2, "R8 enable A locked", rdata_once, 32'h2);
    rd(4'h4, 32'h0, "R7 ctrl B after stop");
    check(rdata_once == 32'h1, "R8 enable B locked", rdata_once, 32'h1);
    quiet_err = 0;
    for (int i = 0; i < 150; i++) begin
      if (irq || rst_req) quiet_err++;
      @(negedge clk);
    end
    check(quiet_err == 0, "R7 no event after full stop", quiet_err, 0);
    check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule